// File: doc/BRIEF.md
# Dual-Rail Completion Detector

This block watches a parameterised bus of dual-rail bits and tells the surrounding handshake logic when a data wave has fully arrived and when the bus has fully drained. Each bit travels on a pair of wires, a one-rail and a zero-rail. The pair tells you both the bit's value and whether the bit is present yet. The block reduces each pair to a single "present" flag by ORing the two rails. It then merges the flags through a balanced tree of two-input Muller C-elements, so that `done` behaves hysteretically.

Each C-element keeps one state bit, held in a register on the sampling clock. A node goes high when both of its inputs are high and goes low when both are low. In every other case the node keeps its old value. The result is that `done` rises only once the whole bus carries codewords, and it falls only once the whole bus has returned to the spacer. A half-arrived or half-drained bus leaves `done` where it was. The block also checks the encoding: a pair with both rails high is not a legal code, and it sets a sticky error flag.

Top module: `dualrail_completion`

## Requirements
- R1: After reset, `done` is 0, `err` is 0, and every tree node is 0.
- R2: Per-bit encoding is as follows. Both rails low means empty. `rail_t`=1 with `rail_f`=0 means logic 1. `rail_t`=0 with `rail_f`=1 means logic 0. A bit counts as present when either of its rails is high. When the bus moves from not-all-present to all-present, `done` rises exactly L clock edges later, where L = max(1, ceil(log2 N)) (3 for N=8). This holds for any mix of 0 and 1 values.
- R3: While `done` is 1 and the bus holds a mix of present and empty bits, `done` stays 1.
- R4: When the bus moves from not-all-empty to all-empty, `done` falls exactly L clock edges later.
- R5: Starting from an empty bus with `done` 0, a bus on which some but not all bits are present keeps `done` at 0.
- R6: A bit with both rails high sets `err` at the next clock edge. `err` then stays 1 through any later legal traffic until reset.
- R7: A bit with both rails high counts as present when completion is detected.
- R8: Legal traffic never sets `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the C-element state and the error flag |
| rst_n | input | 1 | Asynchronous active-low reset |
| rail_t | input | N | One-rail of each bit |
| rail_f | input | N | Zero-rail of each bit |
| done | output | 1 | Hysteretic completion: 1 once all bits are present, 0 once all bits are empty |
| err | output | 1 | Sticky flag for an illegal pair with both rails high |

## Verification
The bench sweeps all 256 presence masks, and for each one it pairs the mask with its own value pattern. This exercises partial arrival, full arrival, partial drain and full drain. A design that used a plain AND for completion would drop `done` during partial drain. A design with a short or long tree would move `done` one edge early or late at the exact-latency samples. A design that ignored the hysteresis would raise `done` on partial arrival. The illegal-pair cases place the bad pair on every bit position. They catch an error flag that clears on legal traffic, one that misses a single bit position, and a presence test that treats the illegal pair as empty, which would leave `done` low.

// File: rtl/drc_pkg.sv
package drc_pkg;

  // number of C-element levels needed to merge n presence flags
  function automatic int tree_levels(input int n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

  // a bit is present when either rail is high
  function automatic logic pair_present(input logic t, input logic f);
    return t | f;
  endfunction

  // both rails high is not a codeword
  function automatic logic pair_illegal(input logic t, input logic f);
    return t & f;
  endfunction

  // next state of a two-input Muller C-element
  function automatic logic c_next(input logic a, input logic b, input logic q);
    return (a & b) | (q & (a | b));
  endfunction

endpackage

// File: rtl/drc_rail_decode.sv
module drc_rail_decode
  import drc_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0] rail_t,
  input  logic [N-1:0] rail_f,
  output logic [N-1:0] present,
  output logic [N-1:0] illegal
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign present[i] = pair_present(rail_t[i], rail_f[i]);
    assign illegal[i] = pair_illegal(rail_t[i], rail_f[i]);
  end

endmodule

// File: rtl/drc_celem.sv
module drc_celem
  import drc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic a,
  input  logic b,
  output logic q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= c_next(a, b, q);
  end

endmodule

// File: rtl/drc_ctree.sv
module drc_ctree
  import drc_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] flags,
  output logic         root
);

  localparam int LVL = tree_levels(N);
  localparam int W   = 1 << LVL;

  // leaves, padded to a power of two by repeating the top flag
  logic [W-1:0] leaf;
  // heap-ordered node states, node 1 is the root
  logic [W-1:1] node;

  for (genvar i = 0; i < W; i++) begin : g_leaf
    if (i < N) begin : g_real
      assign leaf[i] = flags[i];
    end else begin : g_pad
      assign leaf[i] = flags[N-1];
    end
  end

  for (genvar j = 1; j < W; j++) begin : g_node
    logic in_a, in_b;
    if (2 * j < W) begin : g_inner
      assign in_a = node[2*j];
      assign in_b = node[2*j+1];
    end else begin : g_edge
      assign in_a = leaf[2*j-W];
      assign in_b = leaf[2*j+1-W];
    end
    drc_celem u_c (
      .clk  (clk),
      .rst_n(rst_n),
      .a    (in_a),
      .b    (in_b),
      .q    (node[j])
    );
  end

  assign root = node[1];

endmodule

// File: rtl/dualrail_completion.sv
module dualrail_completion
  import drc_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] rail_t,
  input  logic [N-1:0] rail_f,
  output logic         done,
  output logic         err
);

  // named events for the checker
  logic [N-1:0] bit_ok;
  logic [N-1:0] bad_bit;
  logic         err_q;

  drc_rail_decode #(.N(N)) u_dec (
    .rail_t (rail_t),
    .rail_f (rail_f),
    .present(bit_ok),
    .illegal(bad_bit)
  );

  drc_ctree #(.N(N)) u_tree (
    .clk  (clk),
    .rst_n(rst_n),
    .flags(bit_ok),
    .root (done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_q | (|bad_bit);
  end

  assign err = err_q;

endmodule

// File: rtl/drc_check.sv
module drc_check
  import drc_pkg::*;
#(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] bit_ok,
  input logic [N-1:0] bad_bit,
  input logic         done,
  input logic         err
);

  localparam int LVL = tree_levels(N);

  // consecutive cycles with every bit present / every bit empty
  logic [7:0] run_full, run_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_full  <= '0;
      run_empty <= '0;
    end else begin
      run_full  <= (&bit_ok) ? ((run_full  >= 8'(LVL)) ? run_full  : run_full  + 8'd1) : 8'd0;
      run_empty <= (~|bit_ok) ? ((run_empty >= 8'(LVL)) ? run_empty : run_empty + 8'd1) : 8'd0;
    end
  end

  p_full_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_full == 8'(LVL)) |-> done);

  p_empty_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_empty == 8'(LVL)) |-> !done);

  p_rise_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(|bit_ok));

  p_fall_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> $past(~&bit_ok));

  p_err_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|bad_bit) |=> err);

  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  p_err_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(|bad_bit));

endmodule

bind dualrail_completion drc_check #(.N(N)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .bit_ok (bit_ok),
  .bad_bit(bad_bit),
  .done   (done),
  .err    (err)
);

// File: tb/sim_dualrail_completion.sv
`timescale 1ns/1ps
module sim_dualrail_completion;

  localparam int N  = 8;
  localparam int LV = 3;  // max(1, ceil(log2 8))

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] rail_t = '0;
  logic [N-1:0] rail_f = '0;
  logic         done, err;

  int n_cmp = 0;
  int n_bad = 0;
  bit reported = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  dualrail_completion #(.N(N)) u0 (
    .clk   (clk),
    .rst_n (rst_n),
    .rail_t(rail_t),
    .rail_f(rail_f),
    .done  (done),
    .err   (err)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // present mask p, values v: one-rail high for 1, zero-rail high for 0
  task automatic put(input logic [N-1:0] p, input logic [N-1:0] v);
    rail_t = p & v;
    rail_f = p & ~v;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n  = 1'b0;
    rail_t = '0;
    rail_f = '0;
    tick(2);
    rst_n = 1'b1;
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    do_reset();
    chk("R1 done", done, 1'b0);
    chk("R1 err", err, 1'b0);

    for (int m = 0; m < 256; m++) begin
      logic [N-1:0] vals, p1, p2;
      vals = N'(m) ^ 8'hA5;
      p1   = (m == 255) ? 8'h00 : N'(m);
      p2   = (m == 0 || m == 255) ? 8'h3C : N'(m);

      put(p1, vals);              // R5: partial arrival
      tick(LV + 1);
      chk("R5 partial arrival", done, 1'b0);

      put('1, vals);              // R2: full arrival, exact latency
      tick(LV - 1);
      chk("R2 before latency", done, 1'b0);
      tick(1);
      chk("R2 at latency", done, 1'b1);

      put(p2, ~vals);             // R3: partial drain
      tick(LV + 1);
      chk("R3 partial drain", done, 1'b1);

      put('0, '0);                // R4: full drain, exact latency
      tick(LV - 1);
      chk("R4 before latency", done, 1'b1);
      tick(1);
      chk("R4 at latency", done, 1'b0);
      chk("R8 legal traffic", err, 1'b0);
    end

    for (int i = 0; i < N; i++) begin
      do_reset();
      chk("R1 err after reset", err, 1'b0);
      rail_t = N'(1) << i;        // both rails high on bit i only
      rail_f = N'(1) << i;
      tick(1);
      chk("R6 err set", err, 1'b1);
      tick(LV);
      chk("R7 single illegal is partial", done, 1'b0);
      rail_t = '1;                // bit i illegal, others logic 1
      rail_f = N'(1) << i;
      tick(LV);
      chk("R7 illegal counts present", done, 1'b1);
      put('0, '0);
      tick(LV + 1);
      chk("R6 err sticky", err, 1'b1);
      chk("R4 drain after illegal", done, 1'b0);
    end

    do_reset();
    chk("R1 err cleared", err, 1'b0);
    chk("R1 done cleared", done, 1'b0);
    report();
  end

endmodule